// File: doc/BRIEF.md
# Shared Message Interrupt Register Bank

This block collects message-style interrupts into a small set of shared 32-bit registers. A sender posts a message by writing one word to a single "post" offset. The upper bits of that word pick a register and a bit inside it. The block ORs the chosen bit into that register and raises the interrupt line that belongs to the register.

Software services a line by reading the matching register. The read returns the bits collected so far, empties the register and drops its line in the same cycle. A separate summary offset shows at a glance which registers hold anything.

The write strobe and the read strobe are independent and each has its own address. A post and a clearing read can therefore land on the same register in one clock. In that case the freshly posted bit is kept.

Top module: `msg_irq_bank`

## Requirements
- R1: A write at offset 0x140 selects register `wr_data[31:29]` (0 to 7) and bit `wr_data[28:24]` (0 to 31), and ORs that bit into the selected register. Earlier bits are kept.
- R2: The interrupt line `irq[n]` of the selected register is 1 from the clock edge that takes the post write.
- R3: A read at offset `0x10*n` (n = 0 to 7) presents register n's contents on `rd_data` after the edge that takes the read. `rd_data` holds its value until the next read.
- R4: That read leaves register n at zero.
- R5: That read drops `irq[n]` at the same edge. At any time, `irq[n]` is 1 exactly when register n is non-zero.
- R6: A read at offset 0x120 returns a summary in `rd_data[7:0]`, where bit n is 1 when register n is non-zero. Bits 31:8 are zero. This read clears nothing.
- R7: A write whose address has a non-zero low nibble (for example 0x144) changes nothing.
- R8: A write to any offset other than 0x140 (for example 0x000 or 0x100) changes nothing.
- R9: When a post write and a clearing read target the same register in the same cycle, the read returns the old contents. Afterwards the register holds only the new bit, and its line stays high.
- R10: A read at an undefined offset (for example 0x130, 0x008 or 0x080) returns zero and clears no register.
- R11: A synchronous active-low reset empties every register and drops every line.
- R12: A post or a clear on one register leaves every other register and line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write byte offset |
| wr_data | input | 32 | Write data; post fields at bits 31:29 and 28:24 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| irq | output | 8 | One interrupt request per register |

## Verification
The hardest case is a post and a clearing read that hit the same register in one cycle. A design that lets the clear win loses the message and drops the line. A design that lets the post win corrupts the returned word.

Posts with a misaligned address, or to a neighbouring offset, must leave the bank untouched. A loose decoder would set bits from those writes.

Reads of the summary offset and of undefined offsets must neither clear anything nor return stale data. A wrong read decoder would silently empty a register there.

Posts to the top bit, the bottom bit and the last register catch field-position and width slips.

// File: rtl/msg_irq_bank_pkg.sv
// Package: shared types for the message interrupt register bank.
// Assumes: nothing beyond IEEE 1800-2017.
package msg_irq_bank_pkg;

    // Kind of access presented on the read port this cycle.
    typedef enum logic [1:0] {
        RK_IDLE  = 2'd0,
        RK_SLOT  = 2'd1,
        RK_SUM   = 2'd2,
        RK_UNDEF = 2'd3
    } rd_kind_t;

endpackage

// File: rtl/msg_irq_bank_decode.sv
// Module: address and field decoder.
// Turns the write port into a one-hot post vector plus a bit mask, and the
// read port into a one-hot clear vector plus a read kind.
// Assumes: NUM_REGS is a power of two; the register select sits in the top
// field of the data word, with the bit index directly below it.
module msg_irq_bank_decode
    import msg_irq_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 9,
    parameter int POST_OFS = 'h140,
    parameter int SUM_OFS  = 'h120
) (
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [NUM_REGS-1:0]         post_vec,
    output logic [DATA_W-1:0]           post_mask,
    output logic [NUM_REGS-1:0]         clr_vec,
    output rd_kind_t                    rd_kind,
    output logic [$clog2(NUM_REGS)-1:0] rd_slot
);
    localparam int SEL_W   = $clog2(NUM_REGS);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int SEL_LSB = DATA_W - SEL_W;
    localparam int IDX_LSB = SEL_LSB - IDX_W;
    localparam int ROW_W   = ADDR_W - 4;

    logic             post_hit;
    logic [SEL_W-1:0] post_sel;
    logic [IDX_W-1:0] post_idx;
    logic [ROW_W-1:0] rd_row;
    logic             rd_aligned;
    logic             slot_hit;

    // Write side: only a full-address match on the post offset counts.
    always_comb begin
        post_hit  = wr_en && (wr_addr == ADDR_W'(POST_OFS));
        post_sel  = wr_data[SEL_LSB +: SEL_W];
        post_idx  = wr_data[IDX_LSB +: IDX_W];
        post_mask = DATA_W'(1) << post_idx;
        post_vec  = '0;
        if (post_hit) post_vec[post_sel] = 1'b1;
    end

    // Read side: classify the offset and pick the register to clear.
    always_comb begin
        rd_row     = rd_addr[ADDR_W-1:4];
        rd_aligned = (rd_addr[3:0] == 4'h0);
        slot_hit   = rd_aligned && (rd_row < ROW_W'(NUM_REGS));
        rd_slot    = rd_row[SEL_W-1:0];
        clr_vec    = '0;
        if (!rd_en)                              rd_kind = RK_IDLE;
        else if (slot_hit)                       rd_kind = RK_SLOT;
        else if (rd_addr == ADDR_W'(SUM_OFS))    rd_kind = RK_SUM;
        else                                     rd_kind = RK_UNDEF;
        if (rd_kind == RK_SLOT) clr_vec[rd_slot] = 1'b1;
    end
endmodule

// File: rtl/msg_irq_bank_slot.sv
// Module: one shared message register and its interrupt line.
// A post ORs a bit in and raises the line; a clear empties the register and
// drops the line; when both land together, the posted bit survives the clear.
// Assumes: post_mask is one-hot whenever post_en is high.
module msg_irq_bank_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_en,
    input  logic [DATA_W-1:0] post_mask,
    input  logic              clr_en,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    logic [DATA_W-1:0] value_q;
    logic              irq_q;

    // Register contents: clear first, then OR in the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       value_q <= '0;
        else if (post_en) value_q <= (clr_en ? '0 : value_q) | post_mask;
        else if (clr_en)  value_q <= '0;
    end

    // Interrupt line: a post raises it, a clear without a post drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (post_en) irq_q <= 1'b1;
        else if (clr_en)  irq_q <= 1'b0;
    end

    assign value = value_q;
    assign irq   = irq_q;

    assert_post_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        post_en && !clr_en |=> ((value_q & $past(post_mask)) == $past(post_mask))
                               && ((value_q & $past(value_q)) == $past(value_q)));
    assert_post_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post_en |=> irq_q);
    assert_clear_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !post_en |=> value_q == '0);
    assert_line_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (value_q != '0));
    assert_survive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && post_en |=> value_q == $past(post_mask));
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en && !post_en |=> $stable(value_q) && $stable(irq_q));
endmodule

// File: rtl/msg_irq_bank_rdmux.sv
// Module: registered read-data selector.
// Picks a register, the non-zero summary or zero, and holds the result
// until the next read.
// Assumes: values are the pre-clear register contents of the same cycle.
module msg_irq_bank_rdmux
    import msg_irq_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  rd_kind_t                    rd_kind,
    input  logic [$clog2(NUM_REGS)-1:0] rd_slot,
    input  logic [DATA_W-1:0]           values [NUM_REGS],
    output logic [DATA_W-1:0]           rd_data
);
    logic [NUM_REGS-1:0] nonzero;
    logic [DATA_W-1:0]   rd_q;

    // Summary vector: one flag per register that holds any bit.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) nonzero[i] = (values[i] != '0);
    end

    // Read data register: updated only when a read is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else begin
            case (rd_kind)
                RK_SLOT:  rd_q <= values[rd_slot];
                RK_SUM:   rd_q <= {{(DATA_W-NUM_REGS){1'b0}}, nonzero};
                RK_UNDEF: rd_q <= '0;
                default:  rd_q <= rd_q;
            endcase
        end
    end

    assign rd_data = rd_q;

    assert_sum_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_kind == RK_SUM |=> rd_q[DATA_W-1:NUM_REGS] == '0);
    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_kind == RK_UNDEF |=> rd_q == '0);
endmodule

// File: rtl/msg_irq_bank.sv
// Module: top of the shared message interrupt register bank.
// Decodes both ports, keeps one slot per register and registers read data.
// Assumes: write and read ports may be active in the same cycle.
module msg_irq_bank
    import msg_irq_bank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 9,
    parameter int POST_OFS = 'h140,
    parameter int SUM_OFS  = 'h120
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_REGS-1:0] irq
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0] post_vec;
    logic [DATA_W-1:0]   post_mask;
    logic [NUM_REGS-1:0] clr_vec;
    rd_kind_t            rd_kind;
    logic [SEL_W-1:0]    rd_slot;
    logic [DATA_W-1:0]   values [NUM_REGS];

    msg_irq_bank_decode #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .POST_OFS(POST_OFS), .SUM_OFS(SUM_OFS)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .post_vec(post_vec), .post_mask(post_mask), .clr_vec(clr_vec),
        .rd_kind(rd_kind), .rd_slot(rd_slot)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        msg_irq_bank_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .post_en(post_vec[g]), .post_mask(post_mask),
            .clr_en(clr_vec[g]),
            .value(values[g]), .irq(irq[g])
        );
    end

    msg_irq_bank_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_kind(rd_kind), .rd_slot(rd_slot),
        .values(values), .rd_data(rd_data)
    );

    assert_reset_lines_R11: assert property (@(posedge clk)
        !rst_n |=> irq == '0 && rd_data == '0);
    assert_single_post_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_en |=> $countones(irq & ~$past(irq)) <= 1);
endmodule

// File: tb/sim_msg_irq_bank.sv
// Directed bench for msg_irq_bank: one task per scenario, each self-checking.
module sim_msg_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    msg_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_irq();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = (model[i] != 0);
        return v;
    endfunction

    task automatic post(input logic [8:0] a, input int sel, input int idx);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = {sel[2:0], idx[4:0], 24'h0};
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 9'h140) model[sel] = model[sel] | (32'h1 << idx);
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 0;
        chk("R11 irq after reset", 32'(irq), 32'h0);
        chk("R11 rd_data after reset", rd_data, 32'h0);
        rd(9'h120, d);
        chk("R11 summary after reset", d, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        post(9'h140, 3, 5);
        chk("R2 irq after post", 32'(irq), 32'h08);
        rd(9'h120, d);
        chk("R6 summary", d, 32'h08);
        chk("R6 summary read keeps line", 32'(irq), 32'h08);
        rd(9'h030, d);
        chk("R3 read value", d, 32'h20);
        chk("R5 line dropped", 32'(irq), 32'h0);
        model[3] = 0;
        rd(9'h030, d);
        chk("R4 register cleared", d, 32'h0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        post(9'h140, 7, 31);
        post(9'h140, 7, 0);
        post(9'h140, 0, 17);
        chk("R1 lines", 32'(irq), 32'(exp_irq()));
        rd(9'h070, d);
        chk("R1 bits accumulate", d, 32'h8000_0001);
        model[7] = 0;
        chk("R12 other line kept", 32'(irq), 32'h01);
        rd(9'h000, d);
        chk("R12 other register intact", d, 32'h0002_0000);
        model[0] = 0;
    endtask

    task automatic t_ignored_writes();
        logic [31:0] d;
        post(9'h144, 2, 4);
        chk("R7 misaligned write ignored", 32'(irq), 32'h0);
        post(9'h100, 2, 4);
        post(9'h000, 2, 4);
        chk("R8 other offsets ignored", 32'(irq), 32'h0);
        rd(9'h020, d);
        chk("R8 register untouched", d, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        post(9'h140, 1, 2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'h140; wr_data = {3'd1, 5'd9, 24'h0};
        rd_en = 1'b1; rd_addr = 9'h010;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 read returns old contents", rd_data, 32'h4);
        chk("R9 line stays high", 32'(irq), 32'h02);
        rd(9'h010, d);
        chk("R9 new bit survives", d, 32'h200);
    endtask

    task automatic t_undef();
        logic [31:0] d;
        post(9'h140, 4, 12);
        rd(9'h130, d);
        chk("R10 undefined offset reads zero", d, 32'h0);
        rd(9'h048, d);
        chk("R10 misaligned read zero", d, 32'h0);
        rd(9'h080, d);
        chk("R10 past last register zero", d, 32'h0);
        chk("R10 nothing cleared", 32'(irq), 32'h10);
        rd(9'h040, d);
        chk("R3 read after undefined", d, 32'h0000_1000);
    endtask

    task automatic t_reset_midrun();
        post(9'h140, 5, 1);
        post(9'h140, 6, 30);
        chk("R2 two lines", 32'(irq), 32'h60);
        t_reset();
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_ignored_writes();
        t_collide();
        t_undef();
        t_reset_midrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule